// File: doc/BRIEF.md
# Per-Element Saturating Add/Subtract Stage

This block is one lane of a vector integer pipeline. Each cycle it can accept one element: two operands, a choice of add or subtract, a source element width and a destination element width (8, 16 or 32 bits). It returns the result clamped to the destination width. A signedness bit sets both how the operands are extended and which range the result is clamped to. In unsigned mode the range is zero to all-ones. In signed mode it is the two's-complement minimum to maximum.

When the record flag is set, the block also returns a 4-bit condition field for that element. The field holds less-than, greater-than and equal-to-zero bits, taken from the clamped result, plus a saturation bit that reports clamping for this element alone. Saturation is never accumulated into any shared or sticky flag. A request for a carry-producing operation conflicts with saturation and is refused through an illegal flag. An unsupported width code is refused the same way.

The stage has one register. Results appear one clock after the element is accepted.

Top module: `sat_elem_alu`

## Requirements
- R1: With `sgn_mode`=0, the result is the exact sum or difference clamped to the range 0 to 2^D-1, where D is the destination width.
- R2: With `sgn_mode`=1, the result is the exact sum or difference clamped to the range -2^(D-1) to 2^(D-1)-1.
- R3: With `record`=1, bit 0 of `cond_out` is 1 exactly when the clamp changed the value, and 0 otherwise, including for results that land exactly on a bound.
- R4: With `record`=0, `cond_out` is 4'b0000 whatever the result.
- R5: With `record`=1, `cond_out[3]` (less than zero), `cond_out[2]` (greater than zero) and `cond_out[1]` (equal to zero) come from the clamped result. The result is read as signed in signed mode and as unsigned in unsigned mode, so bit 3 is never set in unsigned mode.
- R6: Only the low S bits of each operand are used, S being the source width. They are sign-extended when `sgn_mode`=1 and zero-extended otherwise. Higher operand bits have no effect.
- R7: The intermediate value is kept without wrap at the wider of the two widths plus guard bits. A source wider than the destination therefore clamps and never truncates.
- R8: Width codes are 0 = 8 bits, 1 = 16 bits and 2 = 32 bits. If `carry_req`=1, or either width code is 3, then `illegal` is 1 and both `result` and `cond_out` are zero.
- R9: `valid_out` is high in the cycle after each cycle in which `valid_in` is high, and low otherwise. Output data changes only when an element is accepted.
- R10: Bits of `result` above the destination width are always zero.
- R11: While `rst_n` is low, `valid_out`, `result`, `cond_out` and `illegal` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Element present this cycle |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| sub_sel | input | 1 | 1: a - b, 0: a + b |
| carry_req | input | 1 | Carry-producing operation requested (refused) |
| src_wcode | input | 2 | Source width code |
| dst_wcode | input | 2 | Destination width code |
| sgn_mode | input | 1 | Signed extension and clamp |
| record | input | 1 | Produce condition field |
| valid_out | output | 1 | Result present |
| result | output | 32 | Clamped result, zero above destination width |
| cond_out | output | 4 | {lt, gt, eq, saturated} |
| illegal | output | 1 | Request refused |

## Verification
On every cycle the assertions check the following:
- `valid_out` follows `valid_in` with one cycle of delay.
- Result bits above the destination width stay zero.
- A refused request shows zero data.
- An unrecorded element shows an empty condition field.
- A recorded element has exactly one of lt, gt or eq set.
- A set saturation bit always comes with a result sitting on a bound.

Some properties can only be shown by the bench's vectors, which a full-precision model scores:
- whether a value clamps at all;
- which bound it lands on;
- that a value exactly on a bound is not reported as saturated;
- how operands are extended when the source and destination widths differ.

// File: rtl/sat_pkg.sv
package sat_pkg;
    typedef logic [1:0] wcode_t;
    localparam wcode_t WC_8  = 2'd0;
    localparam wcode_t WC_16 = 2'd1;
    localparam wcode_t WC_32 = 2'd2;
    localparam int CR_LT = 3;
    localparam int CR_GT = 2;
    localparam int CR_EQ = 1;
    localparam int CR_SO = 0;
    localparam int BASE_W = 8;
endpackage

// File: rtl/sat_operand_ext.sv
module sat_operand_ext
    import sat_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int EXT  = XLEN + 2
) (
    input  logic [XLEN-1:0]        x,
    input  wcode_t                 code,
    input  logic                   sgn,
    output logic signed [EXT-1:0]  y
);
    localparam int NW = $clog2(XLEN / BASE_W) + 1;

    logic [EXT-1:0] cand [NW];

    for (genvar g = 0; g < NW; g++) begin : g_w
        localparam int W = BASE_W << g;
        assign cand[g] = {{(EXT-W){sgn & x[W-1]}}, x[W-1:0]};
    end

    always_comb begin
        y = '0;
        for (int i = 0; i < NW; i++) begin
            if (int'(code) == i) y = signed'(cand[i]);
        end
    end
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp
    import sat_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int EXT  = XLEN + 2
) (
    input  logic signed [EXT-1:0] val,
    input  wcode_t                code,
    input  logic                  sgn,
    output logic [XLEN-1:0]       res,
    output logic                  sat
);
    localparam logic signed [EXT-1:0] ONE = EXT'(1);

    int                   dwi;
    logic signed [EXT-1:0] hi, lo, umask, clamped;

    always_comb begin
        dwi   = BASE_W << code;
        umask = (ONE <<< dwi) - ONE;
        if (sgn) begin
            hi = (ONE <<< (dwi - 1)) - ONE;
            lo = -(ONE <<< (dwi - 1));
        end else begin
            hi = umask;
            lo = '0;
        end
        sat = 1'b0;
        clamped = val;
        if (val > hi) begin
            clamped = hi;
            sat = 1'b1;
        end else if (val < lo) begin
            clamped = lo;
            sat = 1'b1;
        end
        res = clamped[XLEN-1:0] & umask[XLEN-1:0];
    end
endmodule

// File: rtl/sat_cond.sv
module sat_cond
    import sat_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] res,
    input  wcode_t          code,
    input  logic            sgn,
    input  logic            sat,
    input  logic            rec,
    output logic [3:0]      cr
);
    int   dwi;
    logic msb, lt, eq, gt;

    always_comb begin
        dwi = BASE_W << code;
        msb = res[dwi-1];
        lt  = sgn & msb;
        eq  = (res == '0);
        gt  = !lt && !eq;
        cr  = '0;
        if (rec) begin
            cr[CR_LT] = lt;
            cr[CR_GT] = gt;
            cr[CR_EQ] = eq;
            cr[CR_SO] = sat;
        end
    end
endmodule

// File: rtl/sat_elem_alu.sv
module sat_elem_alu
    import sat_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid_in,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    input  logic            sub_sel,
    input  logic            carry_req,
    input  logic [1:0]      src_wcode,
    input  logic [1:0]      dst_wcode,
    input  logic            sgn_mode,
    input  logic            record,
    output logic            valid_out,
    output logic [XLEN-1:0] result,
    output logic [3:0]      cond_out,
    output logic            illegal
);
    localparam int EXT = XLEN + 2;
    localparam int NW  = $clog2(XLEN / BASE_W) + 1;

    typedef struct packed {
        logic            vld;
        logic [XLEN-1:0] res;
        logic [3:0]      cr;
        logic            ill;
        logic            sgn;
        logic            rec;
        wcode_t          dw;
    } stage_t;

    stage_t stg_d, stg_q;

    logic                  bad_code, refuse;
    wcode_t                dw_safe;
    logic signed [EXT-1:0] ea, eb, sum_w;
    logic [XLEN-1:0]       clamp_res;
    logic                  clamp_sat;
    logic [3:0]            cr_w;

    always_comb begin
        bad_code = (int'(src_wcode) >= NW) || (int'(dst_wcode) >= NW);
        refuse   = carry_req || bad_code;
        dw_safe  = bad_code ? WC_8 : dst_wcode;
    end

    sat_operand_ext #(.XLEN(XLEN), .EXT(EXT)) u_ext_a (
        .x(opnd_a), .code(src_wcode), .sgn(sgn_mode), .y(ea)
    );
    sat_operand_ext #(.XLEN(XLEN), .EXT(EXT)) u_ext_b (
        .x(opnd_b), .code(src_wcode), .sgn(sgn_mode), .y(eb)
    );

    always_comb sum_w = sub_sel ? (ea - eb) : (ea + eb);

    sat_clamp #(.XLEN(XLEN), .EXT(EXT)) u_clamp (
        .val(sum_w), .code(dw_safe), .sgn(sgn_mode),
        .res(clamp_res), .sat(clamp_sat)
    );

    sat_cond #(.XLEN(XLEN)) u_cond (
        .res(clamp_res), .code(dw_safe), .sgn(sgn_mode),
        .sat(clamp_sat), .rec(record), .cr(cr_w)
    );

    always_comb begin
        stg_d     = stg_q;
        stg_d.vld = valid_in;
        if (valid_in) begin
            stg_d.ill = refuse;
            stg_d.res = refuse ? '0 : clamp_res;
            stg_d.cr  = refuse ? '0 : cr_w;
            stg_d.sgn = sgn_mode;
            stg_d.rec = record && !refuse;
            stg_d.dw  = dw_safe;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign valid_out = stg_q.vld;
    assign result    = stg_q.res;
    assign cond_out  = stg_q.cr;
    assign illegal   = stg_q.ill;

    // Bounds of the held destination width, for the checks below
    logic [XLEN-1:0] chk_mask, chk_hi, chk_lo;
    always_comb begin
        chk_mask = XLEN'((64'(1) << (BASE_W << stg_q.dw)) - 64'(1));
        chk_hi   = stg_q.sgn ? (chk_mask >> 1) : chk_mask;
        chk_lo   = stg_q.sgn ? (chk_mask & ~(chk_mask >> 1)) : '0;
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out); // R9
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> !valid_out); // R9
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> ((result & ~chk_mask) == '0)); // R10
    AST_REFUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_out && illegal) |-> (result == '0 && cond_out == 4'b0)); // R8
    AST_NOREC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_out && !stg_q.rec) |-> (cond_out == 4'b0)); // R4
    AST_ONE_RELATION: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_out && stg_q.rec) |-> ($countones(cond_out[3:1]) == 1)); // R5
    AST_SAT_ON_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_out && cond_out[CR_SO]) |-> (result == chk_hi || result == chk_lo)); // R3
    AST_UNS_NOT_LT: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_out && !stg_q.sgn) |-> !cond_out[CR_LT]); // R5
endmodule

// File: tb/tb_sat_elem_alu.sv
module tb_sat_elem_alu;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        valid_in;
    logic [31:0] opnd_a, opnd_b;
    logic        sub_sel, carry_req, sgn_mode, record;
    logic [1:0]  src_wcode, dst_wcode;
    logic        valid_out, illegal;
    logic [31:0] result;
    logic [3:0]  cond_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    sat_elem_alu dut (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .sub_sel(sub_sel),
        .carry_req(carry_req), .src_wcode(src_wcode), .dst_wcode(dst_wcode),
        .sgn_mode(sgn_mode), .record(record),
        .valid_out(valid_out), .result(result), .cond_out(cond_out),
        .illegal(illegal)
    );

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] b;
        logic        sub;
        logic        cy;
        logic [1:0]  sw;
        logic [1:0]  dw;
        logic        sg;
        logic        rc;
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{32'd200,       32'd100,       1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 4'd1},
        '{32'd5,         32'd7,         1'b1, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 4'd1},
        '{32'd255,       32'd0,         1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 4'd3},
        '{32'h7F,        32'h1,         1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 1'b1, 4'd2},
        '{32'h80,        32'h1,         1'b1, 1'b0, 2'd0, 2'd0, 1'b1, 1'b1, 4'd2},
        '{32'h80,        32'h0,         1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 1'b1, 4'd5},
        '{32'h7FFF,      32'h0,         1'b0, 1'b0, 2'd1, 2'd1, 1'b1, 1'b1, 4'd5},
        '{32'hFFFFFFFF,  32'h1,         1'b0, 1'b0, 2'd2, 2'd2, 1'b0, 1'b1, 4'd1},
        '{32'h7FFFFFFF,  32'h1,         1'b0, 1'b0, 2'd2, 2'd2, 1'b1, 1'b1, 4'd2},
        '{32'h80000000,  32'h1,         1'b1, 1'b0, 2'd2, 2'd2, 1'b1, 1'b1, 4'd2},
        '{32'h100,       32'h0,         1'b0, 1'b0, 2'd2, 2'd0, 1'b0, 1'b1, 4'd7},
        '{32'hFF,        32'h1,         1'b0, 1'b0, 2'd0, 2'd2, 1'b1, 1'b1, 4'd6},
        '{32'hABCD0010,  32'hFFFFFF05,  1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 4'd6},
        '{32'd250,       32'd9,         1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd4},
        '{32'd1,         32'd2,         1'b0, 1'b1, 2'd0, 2'd0, 1'b0, 1'b1, 4'd8},
        '{32'd1,         32'd2,         1'b0, 1'b0, 2'd0, 2'd3, 1'b0, 1'b1, 4'd8},
        '{32'h12345678,  32'h0,         1'b0, 1'b0, 2'd2, 2'd1, 1'b1, 1'b1, 4'd7}
    };

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            4'd9: return "R9";
            4'd10: return "R10";
            default: return "R11";
        endcase
    endfunction

    // Full-precision reference: returns {illegal, cond[3:0], result[31:0]}
    function automatic logic [36:0] model(input vec_t v);
        longint ea, eb, s, hi, lo, c, smask, dmask;
        int sb, db;
        logic lt, gt, eq, sat;
        logic [3:0] cr;
        if (v.cy || v.sw == 2'd3 || v.dw == 2'd3) return {1'b1, 4'b0, 32'b0};
        sb = 8 << v.sw;
        db = 8 << v.dw;
        smask = (longint'(1) << sb) - 1;
        dmask = (longint'(1) << db) - 1;
        ea = longint'(v.a) & smask;
        eb = longint'(v.b) & smask;
        if (v.sg && ea[sb-1]) ea = ea - (longint'(1) << sb);
        if (v.sg && eb[sb-1]) eb = eb - (longint'(1) << sb);
        s = v.sub ? ea - eb : ea + eb;
        hi = v.sg ? (longint'(1) << (db-1)) - 1 : dmask;
        lo = v.sg ? -(longint'(1) << (db-1)) : 0;
        c = s; sat = 1'b0;
        if (s > hi) begin c = hi; sat = 1'b1; end
        if (s < lo) begin c = lo; sat = 1'b1; end
        lt = (c < 0); gt = (c > 0); eq = (c == 0);
        cr = v.rc ? {lt, gt, eq, sat} : 4'b0;
        return {1'b0, cr, 32'(c & dmask)};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        opnd_a = v.a; opnd_b = v.b; sub_sel = v.sub; carry_req = v.cy;
        src_wcode = v.sw; dst_wcode = v.dw; sgn_mode = v.sg; record = v.rc;
    endtask

    bit done = 0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; valid_in = 1'b1;
        drive(VECS[0]);
        repeat (3) @(negedge clk);
        check("R11", {valid_out, illegal, cond_out, result}, 64'h0);
        @(negedge clk);
        rst_n = 1'b1; valid_in = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            valid_in = 1'b1;
            @(negedge clk);
            valid_in = 1'b0;
            check(tag_name(VECS[i].tag), {valid_out, illegal, cond_out, result},
                  {1'b1, model(VECS[i])});
            // R10: bits above destination width zero
            if (VECS[i].dw < 2'd2)
                check("R10", result >> (8 << VECS[i].dw), 64'h0);
        end

        // R9: valid drops after one cycle, data held while idle
        drive(VECS[0]);
        valid_in = 1'b1;
        @(negedge clk);
        valid_in = 1'b0;
        drive(VECS[1]);
        @(negedge clk);
        check("R9", {valid_out, result}, {1'b0, 32'd255});
        // R9: back-to-back elements each appear one cycle later
        drive(VECS[3]); valid_in = 1'b1;
        @(negedge clk);
        check("R9", {valid_out, result}, {1'b1, 32'h7F});
        drive(VECS[4]);
        @(negedge clk);
        valid_in = 1'b0;
        check("R9", {valid_out, result}, {1'b1, 32'h80});

        // R11: reset mid-stream clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check("R11", {valid_out, illegal, cond_out, result}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    end
endmodule